// File: doc/BRIEF.md
# Selectable-Ratio Deserializer with Phased Word Clock

This block turns a serial bit stream into parallel words of 2, 4 or 8 bits. Serial data arrives on a system clock that runs at twice the bit rate. A bit-enable strobe is high on every other cycle and marks the cycles that carry a valid bit. A 2-bit ratio select sets the word width, and the word is presented on a fixed 8-bit bus.

Alongside each word the block produces a word clock that is synchronous to the data. The word clock period is twice the word width in system-clock ticks, which is the bit rate divided by the width. The word clock is high for half of that period. A 2-bit phase select delays the word clock by 0, 90, 180 or 270 degrees relative to the point where the word loads. Because the system clock runs at twice the bit rate, each quarter-period step is a whole number of ticks.

When either select changes, the block discards the partly assembled word and starts counting again. The output stays cleared until the next complete word is loaded.

Top module: `ratio_deser`

## Requirements
- R1: `ratioSel` 00 selects a word width W of 2, 01 selects 4, and 10 or 11 selects 8. A word loads after W accepted bits, where a bit is accepted on a cycle with `bitEn` high.
- R2: Within a word, the i-th accepted bit (counting from 0) appears on `parData[i]`. The first received bit therefore lands on bit 0.
- R3: Output bits at positions W and above are always 0.
- R4: `parData` changes only on the clock edge that accepts the W-th bit of a word, or on a restart. It is stable on every other cycle.
- R5: Once a word has loaded, `wordClk` repeats with a period of 2W ticks and is high for W of them. With `phaseSel` 00 it rises in the same cycle that `parData` takes the new word.
- R6: `phaseSel` value p delays `wordClk` by p*W/2 ticks. `wordClk` is high exactly when ((ticks since the most recent load) - p*W/2) mod 2W is less than W.
- R7: On any cycle where `ratioSel` or `phaseSel` differs from its value in the previous cycle, the block restarts. The bit offered in that cycle and any partial word are discarded, `parData` goes to 0, and `wordClk` stays low until the next full word loads.
- R8: While `rstN` is low, `parData` is 0 and `wordClk` is 0.
- R9: `dataIn` has no effect on cycles where `bitEn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, twice the bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | High on cycles that carry a valid serial bit |
| dataIn | input | 1 | Serial data bit |
| ratioSel | input | 2 | Word width select: 00 gives 2, 01 gives 4, 1x gives 8 |
| phaseSel | input | 2 | Word clock phase: 0, 90, 180 or 270 degrees |
| parData | output | 8 | Parallel word, with the first bit on bit 0 |
| wordClk | output | 1 | Word clock, synchronous to `parData` |

## Verification
`parData` takes a new word on the clock edge that accepts the W-th bit, so the new value is visible one cycle after that bit was driven. A restart clears the output on the edge where the changed select is first seen. `wordClk` is decoded from registered state only, so it moves on the same edge as the tick counter. The bench drives inputs and samples outputs on falling edges. Its tick-level expectation is advanced once per rising edge, so every sample is compared against the state that edge should have produced.

// File: rtl/deser_pkg.sv
package deser_pkg;
  localparam int MAX_WIDTH = 8;
  localparam int IDX_W     = $clog2(MAX_WIDTH);
  localparam int LEN_W     = IDX_W + 1;
  localparam int TICK_W    = LEN_W;

  typedef struct packed {
    logic                 clear;
    logic                 capture;
    logic                 load;
    logic [IDX_W-1:0]     bitIdx;
    logic [MAX_WIDTH-1:0] widthMask;
  } deserCtrl_t;
endpackage

// File: rtl/deser_ctrl.sv
module deser_ctrl
  import deser_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic [1:0] ratioSel,
  input  logic [1:0] phaseSel,
  output deserCtrl_t ctrl,
  output logic       wordClk
);
  logic [1:0]           curRatio, curPhase;
  logic [IDX_W-1:0]     bitCnt, lastIdx;
  logic [TICK_W-1:0]    tickCnt, offset, periodMask, tickRel;
  logic [LEN_W-1:0]     wordLen;
  logic                 armed, restart, loadNow;
  logic [MAX_WIDTH-1:0] maskVec;

  always_comb begin
    case (curRatio)
      2'b00:   wordLen = LEN_W'(2);
      2'b01:   wordLen = LEN_W'(4);
      default: wordLen = LEN_W'(8);
    endcase
  end

  assign lastIdx    = IDX_W'(wordLen - LEN_W'(1));
  assign restart    = (ratioSel != curRatio) || (phaseSel != curPhase);
  assign loadNow    = bitEn && !restart && (bitCnt == lastIdx);

  for (genvar i = 0; i < MAX_WIDTH; i++) begin : g_mask
    assign maskVec[i] = (LEN_W'(i) < wordLen);
  end

  assign ctrl.clear     = restart;
  assign ctrl.capture   = bitEn && !restart;
  assign ctrl.load      = loadNow;
  assign ctrl.bitIdx    = bitCnt;
  assign ctrl.widthMask = maskVec;

  assign offset     = TICK_W'(curPhase) * (wordLen >> 1);
  assign periodMask = ((wordLen - LEN_W'(1)) << 1) | TICK_W'(1);
  assign tickRel    = (tickCnt - offset) & periodMask;
  assign wordClk    = armed && (tickRel < wordLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curRatio <= 2'b00;
      curPhase <= 2'b00;
      bitCnt   <= '0;
      tickCnt  <= '0;
      armed    <= 1'b0;
    end else if (restart) begin
      curRatio <= ratioSel;
      curPhase <= phaseSel;
      bitCnt   <= '0;
      tickCnt  <= '0;
      armed    <= 1'b0;
    end else begin
      tickCnt <= loadNow ? '0 : tickCnt + TICK_W'(1);
      if (bitEn) bitCnt <= loadNow ? '0 : bitCnt + IDX_W'(1);
      if (loadNow) armed <= 1'b1;
    end
  end

  // R1: bit counter never passes the last index of the selected width
  assert_cnt_in_word_R1: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= lastIdx);
  // R7: restart silences the word clock until a new word loads
  assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> !wordClk);
  // R5: zero phase word clock is high right after a load
  assert_zero_phase_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    (loadNow && curPhase == 2'd0) |=> wordClk);
  // R6: level just after a load follows the selected quarter step
  assert_phase_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    loadNow |=> (wordClk == (curPhase == 2'd0 || curPhase == 2'd3)));
endmodule

// File: rtl/deser_datapath.sv
module deser_datapath
  import deser_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dataIn,
  input  deserCtrl_t           ctrl,
  output logic [MAX_WIDTH-1:0] parData
);
  logic [MAX_WIDTH-1:0] asmReg, nextAsm;

  always_comb begin
    nextAsm = asmReg;
    nextAsm[ctrl.bitIdx] = dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asmReg  <= '0;
      parData <= '0;
    end else if (ctrl.clear) begin
      asmReg  <= '0;
      parData <= '0;
    end else begin
      if (ctrl.capture) asmReg <= nextAsm;
      if (ctrl.load) parData <= nextAsm & ctrl.widthMask;
    end
  end

  // R3: positions beyond the word width stay zero
  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (parData & ~ctrl.widthMask) == '0);
  // R4: word held when neither load nor restart
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.load || ctrl.clear) |=> $stable(parData));
  // R7: restart clears the word
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clear |=> parData == '0);
endmodule

// File: rtl/ratio_deser.sv
module ratio_deser
  import deser_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       dataIn,
  input  logic [1:0] ratioSel,
  input  logic [1:0] phaseSel,
  output logic [7:0] parData,
  output logic       wordClk
);
  deserCtrl_t ctrl;

  deser_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitEn    (bitEn),
    .ratioSel (ratioSel),
    .phaseSel (phaseSel),
    .ctrl     (ctrl),
    .wordClk  (wordClk)
  );

  deser_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dataIn  (dataIn),
    .ctrl    (ctrl),
    .parData (parData)
  );
endmodule

// File: tb/ratio_deser_tb.sv
module ratio_deser_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic       dataIn = 1'b0;
  logic [1:0] ratioSel = 2'b00;
  logic [1:0] phaseSel = 2'b00;
  logic [7:0] parData;
  logic       wordClk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench expectation state
  logic [1:0] mR = 2'b00, mP = 2'b00;
  logic [7:0] mAcc = '0, mPar = '0;
  int mCnt = 0, mT = 0;
  bit mArmed = 0;

  ratio_deser u_dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .dataIn(dataIn),
    .ratioSel(ratioSel), .phaseSel(phaseSel),
    .parData(parData), .wordClk(wordClk)
  );

  always #4 clk = ~clk;

  function automatic int widthOf(input logic [1:0] r);
    return (r == 2'b00) ? 2 : (r == 2'b01) ? 4 : 8;
  endfunction

  function automatic logic [7:0] maskOf(input logic [1:0] r);
    return 8'((16'd1 << widthOf(r)) - 1);
  endfunction

  function automatic logic expClk();
    int w, off, rel;
    w = widthOf(mR);
    off = int'(mP) * w / 2;
    rel = ((mT - off) % (2 * w) + 2 * w) % (2 * w);
    return mArmed && (rel < w);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // compare at this falling edge, drive, advance expectation past next rising edge
  task automatic step(input logic [1:0] r, input logic [1:0] p,
                      input logic en, input logic d, input string tag);
    bit rs;
    chk(parData === mPar, tag, "parData", int'(parData), int'(mPar));
    chk(wordClk === expClk(), tag, "wordClk", int'(wordClk), int'(expClk()));
    ratioSel = r; phaseSel = p; bitEn = en; dataIn = d;
    rs = (r != mR) || (p != mP);
    if (rs) begin
      mR = r; mP = p; mCnt = 0; mT = 0; mArmed = 0; mPar = '0;
    end else begin
      mT++;
      if (en) begin
        mAcc[mCnt] = d;
        if (mCnt == widthOf(mR) - 1) begin
          mPar = mAcc & maskOf(mR);
          mArmed = 1; mT = 0; mCnt = 0;
        end else mCnt++;
      end
    end
    @(negedge clk);
  endtask

  task automatic sendBit(input logic [1:0] r, input logic [1:0] p,
                         input logic d, input string tag);
    step(r, p, 1'b1, d, tag);
    step(r, p, 1'b0, 1'($urandom % 2), tag);   // R9: noise while strobe low
  endtask

  task automatic sendWord(input logic [1:0] r, input logic [1:0] p,
                          input logic [7:0] w, input string tag);
    for (int i = 0; i < widthOf(r); i++) sendBit(r, p, w[i], tag);
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(parData === 8'h00, "R8", "reset parData", int'(parData), 0);
    chk(wordClk === 1'b0, "R8", "reset wordClk", int'(wordClk), 0);
    rstN = 1'b1;

    // R1: every encoding, including both 1x codes
    for (int r = 0; r < 4; r++) begin
      step(2'(r), 2'b00, 1'b0, 1'b0, "R1");
      repeat (2) sendWord(2'(r), 2'b00, 8'($urandom), "R1");
    end

    // R2: bit order on an 8-bit word
    step(2'b10, 2'b00, 1'b0, 1'b0, "R2");
    sendWord(2'b10, 2'b00, 8'hB1, "R2");
    chk(parData === 8'hB1, "R2", "first bit on bit 0", int'(parData), 'hB1);

    // R3: narrow word leaves upper bits clear
    step(2'b00, 2'b00, 1'b0, 1'b0, "R3");
    sendWord(2'b00, 2'b00, 8'hFF, "R3");
    chk(parData === 8'h03, "R3", "2-bit word", int'(parData), 'h03);
    step(2'b01, 2'b00, 1'b0, 1'b0, "R3");
    sendWord(2'b01, 2'b00, 8'hFF, "R3");
    chk(parData === 8'h0F, "R3", "4-bit word", int'(parData), 'h0F);

    // R5 / R6: every phase at every width
    for (int r = 0; r < 3; r++)
      for (int p = 0; p < 4; p++) begin
        step(2'(r), 2'(p), 1'b0, 1'b0, (p == 0) ? "R5" : "R6");
        repeat (3) sendWord(2'(r), 2'(p), 8'($urandom), (p == 0) ? "R5" : "R6");
      end

    // R7: change mid-word, offering a bit on the restart cycle
    step(2'b10, 2'b00, 1'b0, 1'b0, "R7");
    sendWord(2'b10, 2'b00, 8'h5A, "R7");
    sendBit(2'b10, 2'b00, 1'b1, "R7");
    sendBit(2'b10, 2'b00, 1'b1, "R7");
    step(2'b01, 2'b00, 1'b1, 1'b1, "R7");
    chk(parData === 8'h00, "R7", "cleared after restart", int'(parData), 0);
    chk(wordClk === 1'b0, "R7", "clock low after restart", int'(wordClk), 0);
    step(2'b01, 2'b00, 1'b0, 1'b0, "R7");
    sendWord(2'b01, 2'b00, 8'h06, "R7");
    chk(parData === 8'h06, "R7", "clean word after restart", int'(parData), 'h06);
    step(2'b01, 2'b10, 1'b0, 1'b0, "R7");
    chk(parData === 8'h00, "R7", "phase change clears", int'(parData), 0);

    // R9: long strobe-low gap with toggling data
    sendBit(2'b01, 2'b10, 1'b1, "R9");
    for (int i = 0; i < 10; i++) step(2'b01, 2'b10, 1'b0, 1'(i % 2), "R9");
    sendBit(2'b01, 2'b10, 1'b0, "R9");
    sendBit(2'b01, 2'b10, 1'b1, "R9");
    sendBit(2'b01, 2'b10, 1'b0, "R9");
    chk(parData === 8'h05, "R9", "gap data ignored", int'(parData), 'h05);

    // R4: random traffic with occasional select changes
    begin
      logic [1:0] rr = 2'b10, pp = 2'b00;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom % 40 == 0) begin
          rr = 2'($urandom);
          pp = 2'($urandom);
        end
        step(rr, pp, 1'(i % 2 == 0), 1'($urandom), "R4");
      end
    end

    done = 1;
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end
endmodule